// File: doc/BRIEF.md
# Toggle-Handshake Serial Bit Sender

This block hands one bit at a time to a slow external host over three wires. The host asks for a bit by flipping the level of its request line. The block brings that line into the clock domain and spots the new level. It then puts the next bit of a repeating pattern on the data line and answers by driving the acknowledge line to the same level as the request. Each level change is one transfer, so the protocol is two-phase. The host reads the data once it sees the acknowledge match its request.

The pattern is a parameter, given as a bit vector and a length. By default it is two entries long, entry 0 being 1 and entry 1 being 0, so the host receives 1,0,1,0,... After reset the block ignores the host for a hold-off period. A prescaler counts clock cycles into a seconds counter, and the block only answers once that counter is above a threshold. The acknowledge and data outputs each pass through two register stages, so the final flop can be placed in the I/O cell.

Top module: `bit_sender_top`

## Requirements
- R1: While the synchronous active-low reset is asserted, and right after it, ACK and DATA are 0. After reset the pattern restarts at entry 0.
- R2: A level change on REQ that is applied between rising edges shows on ACK after the sixth rising edge. Before that edge ACK keeps its old level. This covers three synchroniser stages, one handshake register and two output stages.
- R3: A request is accepted when the synchronised REQ differs both from the last accepted level and from the current ACK level. Once the request is accepted, ACK takes the REQ level.
- R4: Accepted requests send the pattern bits in order, wrapping after the last entry. With the default pattern (entry 0 = 1, entry 1 = 0) DATA reads 1,0,1,0,... DATA changes on the same cycle as ACK.
- R5: While REQ keeps its level, ACK and DATA do not change.
- R6: Requests are ignored until the seconds counter, advanced once every PRESCALE cycles, exceeds SEC_LIMIT (default 1). The counter then stops. A request level still pending at that point is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Asynchronous request line from the host; each level change asks for one bit |
| ack_o | output | 1 | Registered acknowledge; equals the last accepted request level |
| data_o | output | 1 | Registered data bit that belongs to the current acknowledge |

## Verification
The assertions assume that REQ changes at most once per handshake and holds steady for at least three clock cycles. Under that assumption the synchroniser history and the two-phase rule hold. The stimulus changes REQ only on falling clock edges and waits more than six cycles before each check. Reset is held for several cycles, so the delay checks never look back past it. The hold-off is shortened through PRESCALE so that both the ignored and the pending-accept cases fall inside the run.

// File: rtl/bit_sender_pkg.sv
package bit_sender_pkg;
    // Number of register stages on the outputs, after the handshake logic
    localparam int OUT_STAGES = 2;
    // Number of synchroniser flops on the request input
    localparam int SYNC_STAGES = 3;

    typedef struct packed {
        logic ack;
        logic data;
    } hs_word_t;
endpackage

// File: rtl/bs_req_sync.sv
// Brings the asynchronous request line into the clock domain with a
// chain of SYNC_STAGES flops. Only the last flop is used downstream.
// Assumes the input holds each level for longer than the chain length.
module bs_req_sync
    import bit_sender_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [SYNC_STAGES-1:0] chain_q;

    // Shift the raw level through the chain; cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[SYNC_STAGES-1];

    // R2: the synchronised level trails the input by exactly three edges
    p_sync_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 3) |-> (sync_o == $past(async_i, 3)));
endmodule

// File: rtl/bs_holdoff.sv
// Start-up hold-off. A prescaler divides the clock into "seconds".
// done_o goes high once the seconds count exceeds SEC_LIMIT and then
// stays high, and the counter stops there. Restarts on reset.
module bs_holdoff #(
    parameter int PRESCALE  = 50_000_000,
    parameter int SEC_LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int SEC_W  = $clog2(SEC_LIMIT + 2);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [SEC_W-1:0] SEC_END  = SEC_W'(SEC_LIMIT + 1);

    logic [PRE_W-1:0] pre_q;
    logic [SEC_W-1:0] sec_q;

    assign done_o = (sec_q == SEC_END);

    // Count clock cycles into seconds until the hold-off has expired
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            sec_q <= '0;
        end else if (!done_o) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                sec_q <= sec_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R6: the seconds count never passes the stop value
    p_sec_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q <= SEC_END);
    // R6: once expired, the hold-off stays expired until reset
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_o) |-> done_o);
endmodule

// File: rtl/bs_handshake.sv
// Two-phase handshake engine. A request is a synchronised level that
// differs from both the last accepted level and the acknowledge level.
// On a request it records the level, copies it to the acknowledge and
// loads the next pattern bit. Assumes req_i is already synchronised.
module bs_handshake
    import bit_sender_pkg::*;
#(
    parameter int                PAT_LEN  = 2,
    parameter logic [PAT_LEN-1:0] PAT_BITS = 2'b01
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     req_i,
    output hs_word_t word_o
);
    localparam int IDX_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_LEN - 1);

    logic             last_q;
    logic             ack_q;
    logic             data_q;
    logic [IDX_W-1:0] idx_q;
    logic             take;

    assign take = en_i && (req_i != last_q) && (req_i != ack_q);

    // Accept a request: record level, answer, and step the pattern
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            ack_q  <= 1'b0;
            data_q <= 1'b0;
            idx_q  <= '0;
        end else if (take) begin
            last_q <= req_i;
            ack_q  <= req_i;
            data_q <= PAT_BITS[idx_q];
            idx_q  <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    assign word_o.ack  = ack_q;
    assign word_o.data = data_q;

    // R6: the acknowledge can only move after the hold-off has expired
    p_ack_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != $past(ack_q)) |-> $past(en_i));
    // R3: a moved acknowledge always lands on the synchronised request level
    p_ack_matches_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != $past(ack_q)) |-> (ack_q == $past(req_i)));
    // R5: data never moves without a handshake
    p_data_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q != $past(data_q)) |-> (ack_q != $past(ack_q)));
endmodule

// File: rtl/bs_out_pipe.sv
// Plain register stages on the handshake outputs so that the final
// stage has no feedback and can be packed into the I/O flops.
module bs_out_pipe
    import bit_sender_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hs_word_t word_i,
    output hs_word_t word_o
);
    hs_word_t stage_q [OUT_STAGES];

    for (genvar s = 0; s < OUT_STAGES; s++) begin : g_stage
        // Move one stage forward; cleared on reset
        always_ff @(posedge clk) begin
            if (!rst_n)      stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= word_i;
            else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
        end
    end

    assign word_o = stage_q[OUT_STAGES-1];
endmodule

// File: rtl/bit_sender_top.sv
// Toggle-handshake serial bit sender. Synchronises the request line,
// gates requests behind a start-up hold-off, sends pattern bits with a
// two-phase handshake, and registers both outputs twice.
module bit_sender_top
    import bit_sender_pkg::*;
#(
    parameter int                 PRESCALE  = 50_000_000,
    parameter int                 SEC_LIMIT = 1,
    parameter int                 PAT_LEN   = 2,
    parameter logic [PAT_LEN-1:0] PAT_BITS  = 2'b01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic ack_o,
    output logic data_o
);
    logic     req_sync;
    logic     hold_done;
    hs_word_t core_word;
    hs_word_t pin_word;

    bs_req_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (req_i),
        .sync_o  (req_sync)
    );

    bs_holdoff #(
        .PRESCALE  (PRESCALE),
        .SEC_LIMIT (SEC_LIMIT)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (hold_done)
    );

    bs_handshake #(
        .PAT_LEN  (PAT_LEN),
        .PAT_BITS (PAT_BITS)
    ) u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (hold_done),
        .req_i  (req_sync),
        .word_o (core_word)
    );

    bs_out_pipe u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (core_word),
        .word_o (pin_word)
    );

    assign ack_o  = pin_word.ack;
    assign data_o = pin_word.data;

    // R2: pins repeat the handshake word two edges later
    p_out_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (pin_word == $past(core_word, 2)));
endmodule

// File: tb/bit_sender_top_tb_top.sv
`timescale 1ns/1ps
module bit_sender_top_tb_top;
    localparam int PRE = 16;   // hold-off ends 32 cycles after reset

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic ack, data;
    int   total = 0;
    int   bad = 0;

    always #2.5 clk = ~clk;

    bit_sender_top #(.PRESCALE(PRE), .SEC_LIMIT(1)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .ack_o  (ack),
        .data_o (data)
    );

    // {req level, expected ack, expected data}, applied in order
    localparam logic [2:0] VEC [6] = '{
        3'b000, 3'b000, 3'b111, 3'b000, 3'b111, 3'b111
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string rq, input logic [1:0] got, input logic [1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: ack/data got %b expected %b", rq, got, exp);
        end
    endtask

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic prev_req;
        logic [1:0] prev_out;
        step(4);
        check("R1 reset", {ack, data}, 2'b00);
        rst_n = 1'b1;
        req = 1'b1;                         // pending request during hold-off
        step(20);
        check("R6 ignored in hold-off", {ack, data}, 2'b00);
        step(30);
        check("R6 pending accepted, R4 first bit", {ack, data}, 2'b11);

        // Table walk: each toggle checked just before and at the sixth edge
        prev_req = 1'b1;
        prev_out = 2'b11;
        for (int i = 0; i < 6; i++) begin
            req = VEC[i][2];
            step(5);
            check("R2 no early ack", {ack, data}, prev_out);
            step(1);
            if (VEC[i][2] == prev_req)
                check("R5 steady req", {ack, data}, VEC[i][1:0]);
            else
                check("R3/R4 handshake", {ack, data}, VEC[i][1:0]);
            step(4);
            check("R5 hold after", {ack, data}, VEC[i][1:0]);
            prev_req = VEC[i][2];
            prev_out = VEC[i][1:0];
        end

        // Reset mid-run with req high: outputs clear, pattern restarts
        rst_n = 1'b0;
        step(3);
        check("R1 mid reset", {ack, data}, 2'b00);
        rst_n = 1'b1;
        step(20);
        check("R6 hold-off restarts", {ack, data}, 2'b00);
        step(30);
        check("R1 pattern restarts at entry 0", {ack, data}, 2'b11);
        req = 1'b0;
        step(8);
        check("R4 second bit after reset", {ack, data}, 2'b00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule